// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave that holds a 21-byte configuration register file and presents every byte in parallel to the logic around it. A host changes the configuration only with block transfers that always start at byte 0. There is no register addressing. A write carries an address byte, a command byte and a count byte, then data bytes. The command and count bytes are acknowledged and thrown away. The data bytes fill byte 0, byte 1 and onward until the host issues a stop.

A read returns a count byte first, taken from register 8, and then streams bytes from index 0 until the host stops acknowledging. Two byte pairs hold multi-byte divider settings: bytes 11/12 and bytes 13/14. Each pair is staged and copied into the live file only when both of its bytes arrive in the same write. The block also decodes bytes 11 and 12 into a feedback divide value and a reference divide value.

The serial lines are sampled on the system clock through synchronisers. Start and stop conditions are recognised on that clock, so the system clock must run well above the 100 kbit/s bus rate. SDA is open-drain: the block only ever pulls it low.

Top module: `cfg_smbus_slave`

## Requirements
- R1: An address byte of D2h (write) or D3h (read), counting the direction bit, is acknowledged. Any other address byte is not acknowledged, and the slave leaves SDA released for the rest of that transfer up to the next start.
- R2: In a write, the two bytes after the address (command and count) are acknowledged and change no register.
- R3: Write data bytes load byte 0, 1, 2 and onward in order, each acknowledged. A stop after any complete byte ends the write, and bytes not reached keep their values.
- R4: Write data bytes beyond index 20 are acknowledged and discarded.
- R5: Bytes 11/12 and bytes 13/14 change only in the cycle after a stop, and only when both bytes of the pair were received in that write. Otherwise neither byte of the pair changes.
- R6: After reset, byte 7 reads 20h (its top three bits are 001), byte 8 reads 08h and all other bytes read 00h.
- R7: In a read, the first byte sent is the value of byte 8, with 00h reported as 01h. Bytes 0, 1, 2 and onward follow, MSB first, until the host answers a byte with a NACK.
- R8: In a read, byte positions beyond index 20 return FFh.
- R9: fb_div_o equals the 9-bit value {byte12, byte11 bit 7} plus 8. ref_div_o equals byte11 bits 6..0 plus 2.
- R10: SDA is pulled low only while SCL is low (it never changes while SCL is high), and it is released after any start or stop.
- R11: regs_o carries byte k on bits 8k+7 down to 8k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | 168 | Register file, byte k on bits 8k+7..8k |
| fb_div_o | output | 10 | Decoded feedback divide value |
| ref_div_o | output | 8 | Decoded reference divide value |

## Verification
The hardest case to reach from the ports is a write that stops between the two bytes of a divider pair. Both pair bytes must then stay unchanged, while the ordinary bytes written before them do change. The bench reaches this case by ending block writes after a chosen number of data bytes, and it sweeps that stop point across both pairs and past the end of the file. It also sweeps the divider bytes from 00h to FFh. Separate reads, with byte 8 programmed and with 00h in byte 8, test the reported count and the FFh returned past the last register.

// File: rtl/cfg_smbus_pkg.sv
package cfg_smbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXW, ST_ACK, ST_TX, ST_TXA, ST_TXN
  } st_e;

  typedef enum logic [1:0] {
    PH_ADDR, PH_CMD, PH_CNT, PH_DATA
  } ph_e;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edge while SCL held high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int unsigned N_REGS    = 21,
  parameter int unsigned ID_IDX    = 7,
  parameter logic [7:0]  ID_RESET  = 8'h20,
  parameter int unsigned CNT_IDX   = 8,
  parameter logic [7:0]  CNT_RESET = 8'h08,
  parameter int unsigned PAIR_BASE = 11,
  parameter int unsigned N_PAIRS   = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [$clog2(N_REGS)-1:0] wr_idx_i,
  input  logic [7:0]              wr_data_i,
  input  logic                    clr_i,
  input  logic                    commit_i,
  input  logic [7:0]              rd_idx_i,
  output logic [7:0]              rd_data_o,
  output logic [N_REGS*8-1:0]     regs_o
);
  localparam int unsigned IDX_W  = $clog2(N_REGS);
  localparam int unsigned SHD_N  = 2 * N_PAIRS;
  localparam int unsigned SLOT_W = (SHD_N > 1) ? $clog2(SHD_N) : 1;
  localparam logic [IDX_W-1:0] P_LO = IDX_W'(PAIR_BASE);
  localparam logic [IDX_W-1:0] P_HI = IDX_W'(PAIR_BASE + SHD_N);
  localparam logic [7:0] N_REGS_B = 8'(N_REGS);

  logic [7:0] mem [N_REGS];
  logic [7:0] shd [SHD_N];
  logic [SHD_N-1:0] shd_v;
  logic wr_pair;
  logic [SLOT_W-1:0] wr_slot;

  function automatic logic [7:0] rst_val(int unsigned i);
    if (i == ID_IDX)  return ID_RESET;
    if (i == CNT_IDX) return CNT_RESET;
    return 8'h00;
  endfunction

  always_comb begin
    wr_pair = (wr_idx_i >= P_LO) && (wr_idx_i < P_HI);
    wr_slot = SLOT_W'(wr_idx_i - P_LO);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_REGS; i++) mem[i] <= rst_val(i);
      for (int s = 0; s < SHD_N; s++) shd[s] <= 8'h00;
      shd_v <= '0;
    end else begin
      if (clr_i) shd_v <= '0;
      if (wr_en_i) begin
        if (wr_pair) begin
          shd[wr_slot]   <= wr_data_i;
          shd_v[wr_slot] <= 1'b1;
        end else begin
          mem[wr_idx_i] <= wr_data_i;
        end
      end
      if (commit_i) begin
        for (int p = 0; p < N_PAIRS; p++) begin
          if (shd_v[2*p] && shd_v[2*p+1]) begin
            mem[PAIR_BASE+2*p]   <= shd[2*p];
            mem[PAIR_BASE+2*p+1] <= shd[2*p+1];
          end
        end
        shd_v <= '0;
      end
    end
  end

  assign rd_data_o = (rd_idx_i < N_REGS_B) ? mem[rd_idx_i[IDX_W-1:0]] : 8'hFF;

  for (genvar g = 0; g < N_REGS; g++) begin : g_out
    assign regs_o[g*8 +: 8] = mem[g];
  end
endmodule

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave
  import cfg_smbus_pkg::*;
#(
  parameter int unsigned N_REGS      = 21,
  parameter logic [7:0]  WR_ADDR     = 8'hD2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ID_IDX      = 7,
  parameter logic [7:0]  ID_RESET    = 8'h20,
  parameter int unsigned CNT_IDX     = 8,
  parameter logic [7:0]  CNT_RESET   = 8'h08,
  parameter int unsigned DIV_IDX     = 11,
  parameter int unsigned N_PAIRS     = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  output logic [N_REGS*8-1:0] regs_o,
  output logic [9:0]          fb_div_o,
  output logic [7:0]          ref_div_o
);
  localparam logic [7:0] RD_ADDR = WR_ADDR | 8'h01;
  localparam int unsigned IDX_W = $clog2(N_REGS);
  localparam logic [7:0] N_REGS_B = 8'(N_REGS);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  st_e  st;
  ph_e  ph;
  logic [2:0] bit_cnt;
  logic [7:0] sh, idx, idx_nxt, rd_data, cnt_raw, cnt_byte, div_lo, div_hi;
  logic is_rd, wr_en;

  bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  assign wr_en = (st == ST_RXW) && scl_fall && (ph == PH_DATA) && (idx < N_REGS_B)
                 && !start_det && !stop_det;

  cfg_regfile #(
    .N_REGS(N_REGS), .ID_IDX(ID_IDX), .ID_RESET(ID_RESET), .CNT_IDX(CNT_IDX),
    .CNT_RESET(CNT_RESET), .PAIR_BASE(DIV_IDX), .N_PAIRS(N_PAIRS)
  ) u_rf (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(idx[IDX_W-1:0]), .wr_data_i(sh),
    .clr_i(start_det), .commit_i(stop_det),
    .rd_idx_i(idx), .rd_data_o(rd_data), .regs_o
  );

  assign cnt_raw  = regs_o[CNT_IDX*8 +: 8];
  assign cnt_byte = (cnt_raw == 8'h00) ? 8'h01 : cnt_raw;
  assign div_lo   = regs_o[DIV_IDX*8 +: 8];
  assign div_hi   = regs_o[(DIV_IDX+1)*8 +: 8];
  assign fb_div_o  = {1'b0, div_hi, div_lo[7]} + 10'd8;
  assign ref_div_o = {1'b0, div_lo[6:0]} + 8'd2;
  assign idx_nxt   = (idx == 8'hFF) ? idx : idx + 8'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; ph <= PH_ADDR; bit_cnt <= '0; sh <= '0;
      idx <= '0; is_rd <= 1'b0; sda_oe_o <= 1'b0;
    end else if (stop_det) begin
      st <= ST_IDLE; sda_oe_o <= 1'b0;
    end else if (start_det) begin
      st <= ST_RX; ph <= PH_ADDR; bit_cnt <= '0; is_rd <= 1'b0; sda_oe_o <= 1'b0;
    end else begin
      unique case (st)
        ST_RX: if (scl_rise) begin
          sh <= {sh[6:0], sda_s};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) st <= ST_RXW;
        end
        ST_RXW: if (scl_fall) begin
          st <= ST_ACK;
          sda_oe_o <= 1'b1;
          unique case (ph)
            PH_ADDR: begin
              if (sh == WR_ADDR) ph <= PH_CMD;
              else if (sh == RD_ADDR) is_rd <= 1'b1;
              else begin st <= ST_IDLE; sda_oe_o <= 1'b0; end
            end
            PH_CMD:  ph <= PH_CNT;
            PH_CNT:  begin ph <= PH_DATA; idx <= '0; end
            PH_DATA: idx <= idx_nxt;
          endcase
        end
        ST_ACK: if (scl_fall) begin
          bit_cnt <= '0;
          if (is_rd) begin
            sh <= cnt_byte; sda_oe_o <= ~cnt_byte[7]; idx <= '0; st <= ST_TX;
          end else begin
            sda_oe_o <= 1'b0; st <= ST_RX;
          end
        end
        ST_TX: if (scl_fall) begin
          if (bit_cnt == 3'd7) begin
            sda_oe_o <= 1'b0; st <= ST_TXA;
          end else begin
            sh <= {sh[6:0], 1'b0}; sda_oe_o <= ~sh[6]; bit_cnt <= bit_cnt + 3'd1;
          end
        end
        ST_TXA: if (scl_rise) st <= sda_s ? ST_IDLE : ST_TXN;
        ST_TXN: if (scl_fall) begin
          sh <= rd_data; sda_oe_o <= ~rd_data[7]; bit_cnt <= '0;
          idx <= idx_nxt; st <= ST_TX;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_smbus_chk.sv
module cfg_smbus_chk #(
  parameter int unsigned N_REGS  = 21,
  parameter int unsigned DIV_IDX = 11
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                scl_s,
  input logic                scl_fall,
  input logic                start_det,
  input logic                stop_det,
  input logic                sda_oe_o,
  input logic [N_REGS*8-1:0] regs_o
);
  // R10
  sda_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe_o));

  // R10
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  // R1
  start_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe_o);

  // R3
  reg_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_o) |-> ($past(scl_fall) || $past(stop_det)));

  // R5
  pair_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_o[DIV_IDX*8 +: 32]) |-> $past(stop_det));
endmodule

bind cfg_smbus_slave cfg_smbus_chk #(.N_REGS(N_REGS), .DIV_IDX(DIV_IDX)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .sda_oe_o(sda_oe_o), .regs_o(regs_o)
);

// File: tb/tb_cfg_smbus_slave.sv
module tb_cfg_smbus_slave;
  localparam int NR = 21;
  localparam int Q  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic sda_oe;
  logic [NR*8-1:0] regs;
  logic [9:0] fb_div;
  logic [7:0] ref_div;
  wire  sda_line = sda_h & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  logic [7:0] model [NR];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];

  always #10 clk = ~clk;

  cfg_smbus_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_h), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .regs_o(regs), .fb_div_o(fb_div), .ref_div_o(ref_div)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); sda_h = 1; wq(); scl_h = 1; wq(); sda_h = 0; wq(); scl_h = 0; wq(); endtask
  task automatic bus_stop(); sda_h = 0; wq(); scl_h = 1; wq(); sda_h = 1; wq(); wq(); endtask
  task automatic send_bit(input logic b); sda_h = b; wq(); scl_h = 1; wq(); wq(); scl_h = 0; wq(); endtask
  task automatic recv_bit(output logic b); sda_h = 1; wq(); scl_h = 1; wq(); b = sda_line; wq(); scl_h = 0; wq(); endtask

  task automatic wr_byte(input logic [7:0] b, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(a);
    acked = !a;
  endtask

  task automatic rd_byte(output logic [7:0] b, input logic nack);
    for (int i = 7; i >= 0; i--) recv_bit(b[i]);
    send_bit(nack);
  endtask

  task automatic model_write(input int n);
    for (int i = 0; i < n && i < NR; i++)
      if (i < 11 || i > 14) model[i] = wbuf[i];
    if (n >= 13) begin model[11] = wbuf[11]; model[12] = wbuf[12]; end
    if (n >= 15) begin model[13] = wbuf[13]; model[14] = wbuf[14]; end
  endtask

  task automatic do_write(input int n, input string req);
    bit a, all_ok;
    all_ok = 1;
    bus_start();
    wr_byte(8'hD2, a); all_ok &= a;
    wr_byte(8'h5A, a); all_ok &= a;
    wr_byte(8'hA5, a); all_ok &= a;
    for (int i = 0; i < n; i++) begin wr_byte(wbuf[i], a); all_ok &= a; end
    bus_stop();
    model_write(n);
    chk(all_ok, req, "every write byte acknowledged", 32'(all_ok), 1);
  endtask

  task automatic do_read(input int n, output logic [7:0] cnt);
    bit a;
    bus_start();
    wr_byte(8'hD3, a);
    chk(a, "R1", "read address D3h acknowledged", 32'(a), 1);
    rd_byte(cnt, 1'b0);
    for (int i = 0; i < n; i++) rd_byte(rbuf[i], (i == n-1));
    bus_stop();
  endtask

  task automatic check_regs(input string req, input string what);
    int bad;
    bad = -1;
    for (int i = NR-1; i >= 0; i--) if (regs[i*8 +: 8] !== model[i]) bad = i;
    if (bad >= 0) chk(0, req, $sformatf("%s byte %0d", what, bad), 32'(regs[bad*8 +: 8]), 32'(model[bad]));
    else chk(1, req, what, 0, 0);
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 32; i++) wbuf[i] = 8'(i * 37 + seed);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    bit a;
    logic [7:0] cnt;
    logic [9:0] exp_fb;
    logic [7:0] exp_ref;
    for (int i = 0; i < NR; i++) model[i] = 8'h00;
    model[7] = 8'h20; model[8] = 8'h08;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R6 / R11 reset state, R9 decode of zero bytes
    check_regs("R6", "reset value (R11 byte packing)");
    chk(regs[7*8+5 +: 3] == 3'b001, "R6", "byte 7 top bits", 32'(regs[7*8+5 +: 3]), 1);
    chk(fb_div == 10'd8, "R9", "reset fb_div", 32'(fb_div), 8);
    chk(ref_div == 8'd2, "R9", "reset ref_div", 32'(ref_div), 2);
    chk(sda_oe == 1'b0, "R10", "sda released at reset", 32'(sda_oe), 0);

    // R1 foreign address: no ack, stays off the bus
    bus_start();
    wr_byte(8'hA4, a);
    chk(!a, "R1", "foreign address not acked", 32'(a), 0);
    wr_byte(8'h00, a);
    chk(!a, "R1", "following byte not acked", 32'(a), 0);
    bus_stop();
    check_regs("R1", "no change after foreign address");

    // R2 command and count only
    do_write(0, "R2");
    check_regs("R2", "command/count bytes discarded");

    // R3 single byte, then seven bytes
    fill(3);
    do_write(1, "R3");
    check_regs("R3", "stop after byte 0");
    fill(11);
    do_write(7, "R3");
    check_regs("R3", "seven byte write");

    // R5 stop inside pair 11/12
    fill(29);
    do_write(12, "R5");
    check_regs("R5", "half pair 11/12 not loaded");
    chk(regs[11*8 +: 8] == 8'h00, "R5", "byte 11 unchanged", 32'(regs[11*8 +: 8]), 0);
    fill(41);
    do_write(14, "R5");
    check_regs("R5", "pair 11/12 loaded, half pair 13/14 not");

    // R4 beyond end of file
    fill(53);
    do_write(26, "R4");
    check_regs("R4", "bytes past 20 discarded, both pairs loaded");

    // R9 sweep of divider bytes across full range
    for (int k = 0; k < 6; k++) begin
      fill(7 + k);
      wbuf[12] = 8'(k * 51);
      wbuf[11] = 8'(255 - k * 51);
      do_write(15, "R9");
      exp_fb  = 10'(wbuf[12]) * 10'd2 + 10'(wbuf[11][7]) + 10'd8;
      exp_ref = 8'(wbuf[11] % 128) + 8'd2;
      chk(fb_div == exp_fb, "R9", "fb_div", 32'(fb_div), 32'(exp_fb));
      chk(ref_div == exp_ref, "R9", "ref_div", 32'(ref_div), 32'(exp_ref));
    end

    // R7 read with programmed count
    fill(19);
    wbuf[8] = 8'h05;
    do_write(9, "R7");
    do_read(6, cnt);
    chk(cnt == 8'h05, "R7", "count byte", 32'(cnt), 5);
    for (int i = 0; i < 6; i++)
      chk(rbuf[i] == model[i], "R7", $sformatf("read byte %0d", i), 32'(rbuf[i]), 32'(model[i]));
    chk(sda_oe == 1'b0, "R10", "sda released after read stop", 32'(sda_oe), 0);

    // R7 count 00h reported as 01h, R8 past the end
    wbuf[8] = 8'h00;
    do_write(9, "R7");
    do_read(24, cnt);
    chk(cnt == 8'h01, "R7", "count 00h reported as 01h", 32'(cnt), 1);
    for (int i = 0; i < NR; i++)
      chk(rbuf[i] == model[i], "R7", $sformatf("long read byte %0d", i), 32'(rbuf[i]), 32'(model[i]));
    for (int i = NR; i < 24; i++)
      chk(rbuf[i] == 8'hFF, "R8", $sformatf("read past end %0d", i), 32'(rbuf[i]), 32'hFF);
    check_regs("R8", "read leaves registers unchanged");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule